// File: doc/BRIEF.md
# DRAM Mode-Register Command Guard

This block sits between a memory controller's command scheduler and the DRAM command bus. The scheduler offers one decoded command per cycle with a valid strobe. The guard answers in the same cycle with a grant, or with a stall. A stalled command keeps its place and is offered again until it becomes legal. Only granted commands change the guard's state.

The guard enforces three rules. First, it keeps a bitmap of open banks, so that a mode-register write is refused while any row is open. Second, it runs a precharge interval timer, so that a mode-register write waits a set number of cycles after a precharge of all banks. Third, it tracks whether the delay-locked loop (DLL) is on and settled, and it holds reads until the loop has run for a fixed number of cycles since its last enable. Two events enable the loop: a mode-register write with the enable field set, and the exit from self refresh.

A violation flag goes with a stall when waiting alone cannot make the command legal. In that case the scheduler must first issue something else: a precharge, or a DLL enable.

Top module: `dram_cmd_guard`

## Requirements
- R1: A mode-register write (cmd code 4) is granted only when no bank is open. While any bank is open, it gives stall=1, violation=1, grant=0.
- R2: Bank state is tracked per bank. An activate (code 3) opens the bank on `req_bank`. A single-bank precharge (code 2) closes the bank on `req_bank`. A precharge-all (code 1) closes every bank. A single-bank precharge does not start the precharge interval.
- R3: A mode-register write is stalled (violation=0) until TRP cycles after a granted precharge-all. If the precharge-all is granted at cycle t, the write is first granted at cycle t+TRP.
- R4: After reset the DLL is off, every bank is closed and the precharge interval is already met. A read gives stall=1, violation=1, and a mode-register write is granted at once.
- R5: A granted mode-register write with `req_dll_en`=1 turns the DLL on. Reads stall with violation=0 until SETTLE cycles later: granted at t+SETTLE, stalled at t+SETTLE-1.
- R6: A granted self-refresh exit (code 6) turns the DLL on and restarts the same SETTLE-cycle read hold-off.
- R7: A granted mode-register write with `req_dll_en`=0 turns the DLL off. Reads then give stall=1, violation=1 for as long as the DLL stays off.
- R8: The other commands are always granted: code 0 (other), precharge-all, single-bank precharge, activate and self-refresh entry (code 5). Grant and stall are combinational on the offered command. With `req_valid`=0 both are 0. Read is code 7.
- R9: A stalled command has no effect. A refused DLL-enabling write leaves the DLL off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A command is offered this cycle |
| req_cmd | input | 3 | Decoded command code (see R1 to R8) |
| req_bank | input | BANK_W | Bank for activate and single-bank precharge |
| req_dll_en | input | 1 | DLL enable field of a mode-register write |
| grant | output | 1 | Offered command may issue now |
| stall | output | 1 | Offered command must be held |
| violation | output | 1 | Stall that needs another command first |

## Verification
The bench aims at exact edges. It offers the mode-register write at t+TRP-1 and at t+TRP after a precharge-all, and the read at t+SETTLE-1 and at t+SETTLE after each DLL enable. A counter that is off by one would grant one cycle early or stall one cycle too long. The bench also closes the last open bank with a single-bank precharge. A design that clears the bitmap wrongly would refuse the write, and one that starts the interval timer on this command would delay it. The bench then offers a refused DLL-enabling write while a bank is open and checks that reads still report a violation much later. A design that lets stalled commands update state would instead grant those reads.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
    typedef enum logic [2:0] {
        CMD_OTHER    = 3'd0,
        CMD_PRE_ALL  = 3'd1,
        CMD_PRE_BANK = 3'd2,
        CMD_ACT      = 3'd3,
        CMD_MRS      = 3'd4,
        CMD_SR_ENTER = 3'd5,
        CMD_SR_EXIT  = 3'd6,
        CMD_READ     = 3'd7
    } cmd_e;
endpackage

// File: rtl/mrg_bank_map.sv
module mrg_bank_map #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_en,
    input  logic              pre_one_en,
    input  logic              pre_all_en,
    input  logic [BANK_W-1:0] bank,
    output logic              all_closed
);
    typedef struct packed {
        logic [NUM_BANKS-1:0] open;
    } map_t;

    map_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pre_all_en) begin
            st_d.open = '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank == BANK_W'(b)) begin
                    if (act_en)     st_d.open[b] = 1'b1;
                    if (pre_one_en) st_d.open[b] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign all_closed = (st_q.open == '0);

    // R2: an activated bank is open on the following cycle
    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |=> !all_closed);
    // R2: precharge-all leaves nothing open
    p_pre_all_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_en |=> all_closed);
endmodule

// File: rtl/mrg_trp_timer.sv
module mrg_trp_timer #(
    parameter int TRP = 3,
    localparam int CW = $clog2(TRP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic ready
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm)                st_d.cnt = CW'(TRP - 1);
        else if (st_q.cnt != 0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready = (st_q.cnt == '0);

    // R3: counter walks down by one per cycle while the interval runs
    p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !arm) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    // R3: arming with an interval above one cycle blocks the next cycle
    p_arm_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && TRP > 1) |=> !ready);
endmodule

// File: rtl/mrg_dll_settle.sv
module mrg_dll_settle #(
    parameter int SETTLE = 200,
    localparam int CW = $clog2(SETTLE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_ev,
    input  logic disable_ev,
    output logic dll_on,
    output logic read_ok
);
    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
    } dll_t;

    dll_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable_ev) begin
            st_d.on  = 1'b1;
            st_d.cnt = CW'(SETTLE - 1);
        end else if (disable_ev) begin
            st_d.on  = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.cnt != 0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dll_on  = st_q.on;
    assign read_ok = st_q.on && (st_q.cnt == '0);

    // R5 / R6: any enable event holds reads off on the next cycle
    p_enable_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_ev && SETTLE > 1) |=> !read_ok);
    // R7: a disable leaves the DLL off and reads blocked
    p_disable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_ev && !enable_ev) |=> (!dll_on && !read_ok));
    // R6: while off, the DLL stays off without an enable event
    p_stays_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dll_on && !enable_ev) |=> !dll_on);
endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard #(
    parameter int NUM_BANKS = 4,
    parameter int TRP       = 3,
    parameter int SETTLE    = 200,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_dll_en,
    output logic              grant,
    output logic              stall,
    output logic              violation
);
    import mrg_pkg::*;

    cmd_e cmd;
    logic all_closed, trp_ready, dll_on, read_ok;
    logic is_mrs, is_read, legal;

    assign cmd     = cmd_e'(req_cmd);
    assign is_mrs  = req_valid && (cmd == CMD_MRS);
    assign is_read = req_valid && (cmd == CMD_READ);

    always_comb begin
        legal = 1'b1;
        if (is_mrs)  legal = all_closed && trp_ready;
        if (is_read) legal = read_ok;
    end

    assign grant     = req_valid && legal;
    assign stall     = req_valid && !legal;
    assign violation = (is_mrs && !all_closed) || (is_read && !dll_on);

    mrg_bank_map #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_en     (grant && cmd == CMD_ACT),
        .pre_one_en (grant && cmd == CMD_PRE_BANK),
        .pre_all_en (grant && cmd == CMD_PRE_ALL),
        .bank       (req_bank),
        .all_closed (all_closed)
    );

    mrg_trp_timer #(.TRP(TRP)) u_trp (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (grant && cmd == CMD_PRE_ALL),
        .ready (trp_ready)
    );

    mrg_dll_settle #(.SETTLE(SETTLE)) u_dll (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_ev  (grant && ((cmd == CMD_MRS && req_dll_en) || cmd == CMD_SR_EXIT)),
        .disable_ev (grant && cmd == CMD_MRS && !req_dll_en),
        .dll_on     (dll_on),
        .read_ok    (read_ok)
    );

    // R8: grant and stall never together, nothing without a request
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && stall));
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !stall && !violation));
    // R1: a violation is always a stall
    p_viol_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> stall);
    // R9: a stalled mode-register write leaves the DLL state unchanged
    p_stalled_mrs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mrs && stall) |=> (dll_on == $past(dll_on)));
endmodule

// File: tb/dram_cmd_guard_test.sv
module dram_cmd_guard_test;
    localparam int NB = 4;
    localparam int TRP = 3;
    localparam int SETTLE = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic req_dll_en = 1'b0;
    logic grant, stall, violation;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_cmd_guard #(.NUM_BANKS(NB), .TRP(TRP), .SETTLE(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_dll_en(req_dll_en),
        .grant(grant), .stall(stall), .violation(violation)
    );

    // {cmd[3], bank[2], dll_en, exp_grant, exp_stall, exp_viol, req[4]}
    localparam logic [12:0] VEC [17] = '{
        {3'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4}, // R4 read with DLL off
        {3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4}, // R4 MRS at once
        {3'd3, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 activate bank 2
        {3'd4, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1}, // R1 MRS, bank open
        {3'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 precharge bank 1
        {3'd4, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2}, // R2 bank 2 still open
        {3'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 precharge bank 2
        {3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 closed, no interval
        {3'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 activate bank 0
        {3'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 activate bank 3
        {3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 precharge-all at t
        {3'd4, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 t+1 stall
        {3'd4, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 t+2 stall
        {3'd4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 t+3 grant, DLL on
        {3'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 settling
        {3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}, // R8 other
        {3'd5, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}  // R8 self-refresh entry
    };

    task automatic chk(input int req, input string what, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic offer(input int req, input logic [2:0] c, input logic [1:0] b, input logic d,
                         input logic eg, input logic es, input logic ev);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_bank = b; req_dll_en = d;
        #1;
        chk(req, "grant", grant, eg);
        chk(req, "stall", stall, es);
        chk(req, "violation", violation, ev);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            if (grant !== 1'b0 || stall !== 1'b0) begin
                chk(8, "idle grant/stall", grant | stall, 1'b0); // R8
            end
        end
        total++; // R8: idle window summarised as one check
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R8 / R4: in reset and idle, outputs low
        #1;
        chk(8, "reset grant", grant, 1'b0);
        chk(8, "reset stall", stall, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < 17; k++) begin
            offer(int'(VEC[k][3:0]), VEC[k][12:10], VEC[k][9:8], VEC[k][7],
                  VEC[k][6], VEC[k][5], VEC[k][4]);
        end

        // R5: MRS enable was at table step 13 (t); last step is t+3
        idle(195);
        offer(5, 3'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0); // t+199
        offer(5, 3'd7, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0); // t+200

        // R6: self-refresh exit restarts the hold-off
        offer(6, 3'd6, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0); // u
        offer(6, 3'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0); // u+1
        idle(197);
        offer(6, 3'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0); // u+199
        offer(6, 3'd7, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0); // u+200

        // R7: disabling the DLL blocks reads indefinitely
        offer(7, 3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        offer(7, 3'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        idle(250);
        offer(7, 3'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);

        // R9: refused enabling write leaves DLL off
        offer(9, 3'd3, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        offer(9, 3'd4, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
        offer(9, 3'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        idle(210);
        offer(9, 3'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        offer(1, 3'd4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); // R1 now legal

        // R4: reset mid-run clears banks and DLL
        offer(8, 3'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        offer(4, 3'd7, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        offer(4, 3'd4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule